// File: doc/BRIEF.md
# LPC I/O Cycle Target with Wait-State SYNC

This block is the peripheral end of a Low Pin Count bus I/O transfer. It follows the frame strobe and the 4-bit multiplexed address/data lines on the bus clock. It decodes the cycle type and the 16-bit I/O address, and it claims only those cycles whose address falls inside an inclusive window given by two input ports. For a claimed cycle it raises a request on a simple local register port. It holds the bus in wait states until the local side acknowledges, and then it completes the handshake on the bus.

Every transfer carries exactly one byte. Wider host accesses reach the block as separate byte cycles. While the local side is busy, the block sends the long-wait SYNC code on each clock and never switches to the short-wait code. It has no timeout of its own, so a slow register simply stretches the cycle. A frame strobe seen in the middle of a cycle cancels the cycle, and decoding starts again.

Top module: `lpc_io_responder`

## Requirements
- R1: While reset is held and in the first cycle after reset, the target does not drive the bus (`busAdOe` low) and `locReq` is low.
- R2: Only addresses A with `winBase <= A <= winLimit` are claimed. For any other address the bus is never driven and no local request is raised.
- R3: A cycle starts on a clock with `busFrameN` low and nibble 0000. The next nibble selects the type: 000x is an I/O read, 001x is an I/O write. Any other type nibble is ignored and the bus is not driven.
- R4: The four address nibbles arrive most significant first. Write data arrives as two nibbles, low nibble first. While `locReq` is high, `locAddr`, `locWrite` and `locWdata` hold the decoded cycle and stay stable.
- R5: On a claimed cycle the host has two turnaround clocks after the last host nibble. The target drives its first SYNC nibble on the next clock, which is well within the host's three-clock limit.
- R6: Every wait state is the long-wait code 0110. It repeats on every clock while the local side has not acknowledged, with no upper limit. There is always at least one wait state, so the count of wait clocks is one more than the number of request clocks that pass without an acknowledge.
- R7: On the clock after `locAck` is sampled high, the target drives the ready code 0000. For a read, the byte follows on the next two clocks, low nibble first.
- R8: Every completed cycle ends with one clock of 1111 driven by the target, after which the target releases the bus on the following clock.
- R9: `locReq` rises when the wait phase begins and stays high until the clock on which `locAck` is sampled high. There is one request per bus cycle.
- R10: If `busFrameN` goes low in the middle of a cycle, the target releases the bus and drops `locReq` on the next clock and starts decoding again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busFrameN | input | 1 | Frame strobe from the host, active low |
| busAdIn | input | 4 | Nibble sampled from the multiplexed bus lines |
| busAdOut | output | 4 | Nibble driven by the target |
| busAdOe | output | 1 | Output enable for `busAdOut` |
| winBase | input | 16 | Lowest claimed I/O address |
| winLimit | input | 16 | Highest claimed I/O address |
| locReq | output | 1 | Local register access request |
| locWrite | output | 1 | High for a write access |
| locAddr | output | 16 | Local access address |
| locWdata | output | 8 | Local write byte |
| locRdata | input | 8 | Local read byte, taken when `locAck` is high |
| locAck | input | 1 | Local side ready, one-clock pulse |

## Verification
The bench uses random reads and writes, with addresses spread both inside and outside the window and with random local response delays. Any error in the address nibble order, the data nibble order or the window compare therefore shows up as a wrong local address, wrong local data or a wrongly claimed cycle. Directed cases cover the window edges and one address on each side of them, a type nibble that is not an I/O code, and a very long local delay that would expose a hidden timeout. They also cover aborts during the address phase and during wait states. Counting the wait clocks against the programmed delay separates a correct one-clock acknowledge path from one that is off by a clock or that changes the wait code.

// File: rtl/lpc_resp_pkg.sv
package lpc_resp_pkg;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] NIB_TAR    = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDATA, ST_HTAR,
    ST_SYNC, ST_READY, ST_RDATA, ST_TEND, ST_TREL
  } lpcState_e;

  typedef enum logic [2:0] {
    DRV_NONE, DRV_WAIT, DRV_OK, DRV_RLO, DRV_RHI, DRV_TAR
  } drvSel_e;

  typedef struct packed {
    logic    shiftAddr;
    logic    shiftData;
    logic    setDir;
    logic    latchRd;
    drvSel_e drv;
  } dpCtl_t;

endpackage

// File: rtl/lpc_resp_dp.sv
module lpc_resp_dp
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [3:0]        adIn,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic [7:0]        locRdata,
  output logic              winHit,
  output logic              isWrite,
  output logic [ADDR_W-1:0] locAddr,
  output logic [7:0]        locWdata,
  output logic [3:0]        adOut,
  output logic              adOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [7:0]        wdataQ;
  logic [7:0]        rdataQ;
  logic              isWriteQ;

  // address including the nibble on the bus this clock
  assign addrNext = {addrQ[ADDR_W-5:0], adIn};
  assign winHit   = (addrNext >= winBase) && (addrNext <= winLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      isWriteQ <= 1'b0;
    end else begin
      if (ctl.shiftAddr) addrQ    <= addrNext;
      if (ctl.shiftData) wdataQ   <= {adIn, wdataQ[7:4]};
      if (ctl.setDir)    isWriteQ <= adIn[1];
      if (ctl.latchRd)   rdataQ   <= locRdata;
    end
  end

  always_comb begin
    unique case (ctl.drv)
      DRV_WAIT: adOut = SYNC_LONG;
      DRV_OK:   adOut = SYNC_READY;
      DRV_RLO:  adOut = rdataQ[3:0];
      DRV_RHI:  adOut = rdataQ[7:4];
      DRV_TAR:  adOut = NIB_TAR;
      default:  adOut = NIB_TAR;
    endcase
  end

  assign adOe     = (ctl.drv != DRV_NONE);
  assign isWrite  = isWriteQ;
  assign locAddr  = addrQ;
  assign locWdata = wdataQ;

endmodule

// File: rtl/lpc_resp_ctrl.sv
module lpc_resp_ctrl
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] adIn,
  input  logic       winHit,
  input  logic       isWrite,
  input  logic       locAck,
  output dpCtl_t     ctl,
  output logic       locReq
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int CNT_W     = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  lpcState_e       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    stateNxt      = state;
    cntNxt        = cnt;
    ctl.shiftAddr = 1'b0;
    ctl.shiftData = 1'b0;
    ctl.setDir    = 1'b0;
    ctl.latchRd   = 1'b0;
    unique case (state)
      ST_SYNC:  ctl.drv = DRV_WAIT;
      ST_READY: ctl.drv = DRV_OK;
      ST_RDATA: ctl.drv = (cnt == '0) ? DRV_RLO : DRV_RHI;
      ST_TEND:  ctl.drv = DRV_TAR;
      default:  ctl.drv = DRV_NONE;
    endcase

    if (!frameN) begin
      // frame strobe: start a new cycle or abandon the current one
      stateNxt = (adIn == NIB_START) ? ST_CTYPE : ST_IDLE;
      cntNxt   = '0;
    end else begin
      unique case (state)
        ST_CTYPE: begin
          if (adIn[3:2] == 2'b00) begin
            ctl.setDir = 1'b1;
            stateNxt   = ST_ADDR;
            cntNxt     = '0;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        ST_ADDR: begin
          ctl.shiftAddr = 1'b1;
          if (cnt == LAST_ADDR) begin
            cntNxt = '0;
            if (!winHit)      stateNxt = ST_IDLE;
            else if (isWrite) stateNxt = ST_WDATA;
            else              stateNxt = ST_HTAR;
          end else begin
            cntNxt = cnt + ONE;
          end
        end
        ST_WDATA: begin
          ctl.shiftData = 1'b1;
          if (cnt == ONE) begin
            stateNxt = ST_HTAR;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + ONE;
          end
        end
        ST_HTAR: begin
          if (cnt == ONE) begin
            stateNxt = ST_SYNC;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + ONE;
          end
        end
        ST_SYNC: begin
          if (locAck) begin
            ctl.latchRd = 1'b1;
            stateNxt    = ST_READY;
          end
        end
        ST_READY: stateNxt = isWrite ? ST_TEND : ST_RDATA;
        ST_RDATA: begin
          if (cnt == ONE) begin
            stateNxt = ST_TEND;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + ONE;
          end
        end
        ST_TEND: stateNxt = ST_TREL;
        ST_TREL: stateNxt = ST_IDLE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign locReq = (state == ST_SYNC);

endmodule

// File: rtl/lpc_io_responder.sv
module lpc_io_responder
  import lpc_resp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busFrameN,
  input  logic [3:0]        busAdIn,
  output logic [3:0]        busAdOut,
  output logic              busAdOe,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  output logic              locReq,
  output logic              locWrite,
  output logic [ADDR_W-1:0] locAddr,
  output logic [7:0]        locWdata,
  input  logic [7:0]        locRdata,
  input  logic              locAck
);

  dpCtl_t ctl;
  logic   winHit;
  logic   isWrite;

  lpc_resp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (busFrameN),
    .adIn    (busAdIn),
    .winHit  (winHit),
    .isWrite (isWrite),
    .locAck  (locAck),
    .ctl     (ctl),
    .locReq  (locReq)
  );

  lpc_resp_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .adIn     (busAdIn),
    .winBase  (winBase),
    .winLimit (winLimit),
    .locRdata (locRdata),
    .winHit   (winHit),
    .isWrite  (isWrite),
    .locAddr  (locAddr),
    .locWdata (locWdata),
    .adOut    (busAdOut),
    .adOe     (busAdOe)
  );

  assign locWrite = isWrite;

endmodule

// File: rtl/lpc_resp_checker.sv
module lpc_resp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busFrameN,
  input logic [3:0]        busAdOut,
  input logic              busAdOe,
  input logic              locReq,
  input logic              locAck,
  input logic [ADDR_W-1:0] locAddr
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busAdOe && !locReq)); // R1

  AST_WAIT_CODE_LONG: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && busAdOe) |-> (busAdOut == 4'b0110)); // R6

  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && locAck && busFrameN) |=> (busAdOe && busAdOut == 4'b0000 && !locReq)); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && !locAck && busFrameN) |=> locReq); // R9

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && $past(locReq)) |-> $stable(locAddr)); // R4

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!busFrameN) |=> (!busAdOe && !locReq)); // R10

endmodule

bind lpc_io_responder lpc_resp_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busFrameN (busFrameN),
  .busAdOut  (busAdOut),
  .busAdOe   (busAdOe),
  .locReq    (locReq),
  .locAck    (locAck),
  .locAddr   (locAddr)
);

// File: tb/lpc_io_responder_test.sv
module lpc_io_responder_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] WIN_LO = 16'h0300;
  localparam logic [15:0] WIN_HI = 16'h031F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busFrameN = 1'b1;
  logic [3:0]  busAdIn = 4'hF;
  logic [3:0]  busAdOut;
  logic        busAdOe;
  logic [15:0] winBase = WIN_LO;
  logic [15:0] winLimit = WIN_HI;
  logic        locReq;
  logic        locWrite;
  logic [15:0] locAddr;
  logic [7:0]  locWdata;
  logic [7:0]  locRdata = 8'h00;
  logic        locAck = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          respDelay = 0;
  int          reqCnt = 0;
  logic [15:0] expAddr = '0;
  logic        expWr = 1'b0;
  logic [7:0]  expWd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_io_responder uut (
    .clk(clk), .rstN(rstN), .busFrameN(busFrameN), .busAdIn(busAdIn),
    .busAdOut(busAdOut), .busAdOe(busAdOe), .winBase(winBase), .winLimit(winLimit),
    .locReq(locReq), .locWrite(locWrite), .locAddr(locAddr), .locWdata(locWdata),
    .locRdata(locRdata), .locAck(locAck)
  );

  function automatic logic [7:0] expRd(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // local register model: acknowledges after respDelay waiting clocks
  initial forever begin
    @(negedge clk);
    if (locReq && !locAck) begin
      if (reqCnt == respDelay) begin
        chk(locAddr == expAddr, "R4 local address", locAddr, expAddr);
        chk(locWrite == expWr, "R4 local direction", locWrite, expWr);
        if (expWr) chk(locWdata == expWd, "R4 local write data", locWdata, expWd);
        locRdata = expRd(locAddr);
        locAck = 1'b1;
        reqCnt = 0;
      end else begin
        reqCnt++;
      end
    end else begin
      locAck = 1'b0;
      if (!locReq) reqCnt = 0;
    end
  end

  // abortAt >= 0: pull the frame strobe after that many wait clocks
  task automatic runCycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input int dly, input int abortAt);
    bit claim;
    int waits;
    logic [7:0] rd;
    claim = (a >= WIN_LO) && (a <= WIN_HI);
    expAddr = a; expWr = wr; expWd = d; respDelay = dly;
    rd = expRd(a);
    @(negedge clk); busFrameN = 1'b0; busAdIn = 4'b0000;
    @(negedge clk); busFrameN = 1'b1;
    busAdIn = (wr ? 4'b0010 : 4'b0000) | 4'($urandom_range(0, 1));
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      chk(!busAdOe, "R5 target quiet during header", busAdOe, 0);
      busAdIn = a[i*4 +: 4];
    end
    if (wr) begin
      @(negedge clk); busAdIn = d[3:0];
      @(negedge clk); busAdIn = d[7:4];
    end
    @(negedge clk); busAdIn = 4'hF;
    @(negedge clk); busAdIn = 4'hF;
    @(negedge clk);
    if (!claim) begin
      for (int k = 0; k < 10; k++) begin
        chk(!busAdOe && !locReq, "R2 outside window untouched", {busAdOe, locReq}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(busAdOe && busAdOut == 4'b0110, "R5 first SYNC after turnaround", {busAdOe, busAdOut}, 5'h16);
    waits = 0;
    while (busAdOe && busAdOut == 4'b0110 && waits < 2000) begin
      if (waits == abortAt) begin
        busFrameN = 1'b0; busAdIn = 4'h5;
        @(negedge clk);
        chk(!busAdOe && !locReq, "R10 abort releases bus", {busAdOe, locReq}, 0);
        busFrameN = 1'b1; busAdIn = 4'hF;
        return;
      end
      waits++;
      @(negedge clk);
    end
    chk(waits == dly + 1, "R6 wait clocks of code 0110", waits, dly + 1);
    chk(busAdOe && busAdOut == 4'b0000, "R7 ready SYNC", {busAdOe, busAdOut}, 5'h10);
    if (!wr) begin
      @(negedge clk);
      chk(busAdOe && busAdOut == rd[3:0], "R7 read low nibble", busAdOut, rd[3:0]);
      @(negedge clk);
      chk(busAdOe && busAdOut == rd[7:4], "R7 read high nibble", busAdOut, rd[7:4]);
    end
    @(negedge clk);
    chk(busAdOe && busAdOut == 4'b1111, "R8 end turnaround drive", {busAdOe, busAdOut}, 5'h1F);
    @(negedge clk);
    chk(!busAdOe, "R8 bus released", busAdOe, 0);
  endtask

  task automatic badType(input logic [3:0] typ, input logic [15:0] a);
    @(negedge clk); busFrameN = 1'b0; busAdIn = 4'b0000;
    @(negedge clk); busFrameN = 1'b1; busAdIn = typ;
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk); busAdIn = a[i*4 +: 4];
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); busAdIn = 4'hF;
      chk(!busAdOe && !locReq, "R3 non-I/O type ignored", {busAdOe, locReq}, 0);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!busAdOe && !locReq, "R1 reset quiet", {busAdOe, locReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busAdOe && !locReq, "R1 after reset quiet", {busAdOe, locReq}, 0);

    // directed: window edges, both directions (R2)
    runCycle(1'b0, WIN_LO, 8'h00, 0, -1);
    runCycle(1'b1, WIN_HI, 8'hA5, 1, -1);
    runCycle(1'b0, WIN_LO - 16'd1, 8'h00, 0, -1);
    runCycle(1'b1, WIN_HI + 16'd1, 8'h5A, 0, -1);
    // long local delay, no timeout (R6)
    runCycle(1'b0, 16'h0310, 8'h00, 300, -1);
    // types that are not I/O (R3)
    badType(4'b0100, 16'h0305);
    badType(4'b1110, 16'h0306);
    // abort during address phase (R10)
    @(negedge clk); busFrameN = 1'b0; busAdIn = 4'b0000;
    @(negedge clk); busFrameN = 1'b1; busAdIn = 4'b0000;
    @(negedge clk); busAdIn = 4'h0;
    @(negedge clk); busFrameN = 1'b0; busAdIn = 4'h5;
    @(negedge clk); busFrameN = 1'b1; busAdIn = 4'hF;
    chk(!busAdOe && !locReq, "R10 abort in address phase", {busAdOe, locReq}, 0);
    runCycle(1'b1, 16'h0301, 8'h3C, 0, -1);
    // abort during wait states, then a normal cycle (R10)
    runCycle(1'b0, 16'h0308, 8'h00, 20, 3);
    @(negedge clk);
    runCycle(1'b0, 16'h0308, 8'h00, 2, -1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      if ($urandom_range(0, 1) == 1) a = WIN_LO + 16'($urandom_range(0, 31));
      else a = 16'($urandom);
      runCycle(1'($urandom_range(0, 1)), a, 8'($urandom), $urandom_range(0, 6), -1);
    end
    finish();
  end

endmodule